// File: doc/BRIEF.md
# GPIO Bank with Blink Control

A bank of general-purpose pins with four registers on a simple bus port. Per pin it holds a use-select bit (1 = plain GPIO, 0 = native function), a direction bit (1 = output, 0 = input), a level bit and a blink-enable bit. An output pin drives its stored level. An input pin's level bit reads back the pin state after a two-flop synchroniser. A blink-enable bit makes an output pin follow a shared blink phase instead, toggling every half second of clock cycles, and the stored level stays untouched.

Register bits belong to one of two reset domains. A parameter mask assigns each pin to a domain, and by default pins 0–7 and 16–23 are core and pins 8–15 and 24–31 are resume. The core reset clears only core-domain bits of the use-select, direction and level registers. The resume reset clears the resume-domain bits of those registers, every blink bit and the blink timebase. A one-cycle software strobe restores only the blink register.

The bus writes on the clock edge while the write enable is high, and read data follows the address combinationally.

Top module: `gpio_blink_bank`

## Requirements
- R1: After both resets, use-select reads FFFFFFFFh, direction reads 00040000h, blink reads 00040000h and the stored level is 02FE0000h, so pin 18 drives the blink phase straight away.
- R2: Pin output enable is 1 exactly when the pin's use-select bit and direction bit are both 1. A level write to such a pin updates the stored bit, and the pin output follows it from the next cycle.
- R3: For a GPIO input pin (use-select 1, direction 0), the level read returns the pin state two clock edges after it changes, and a level write leaves the stored bit unchanged.
- R4: For a native pin (use-select 0), the level read returns 0, a level write leaves the stored bit unchanged, and output enable is 0.
- R5: A blinking output pin holds each pin-output value for exactly CLK_HZ/(2*BLINK_HZ) cycles. The stored level is not altered while the pin blinks.
- R6: A blink bit set on an input pin has no effect. Output enable stays 0, and the level read still returns the pin state.
- R7: When the blink bit is cleared, the output pin drives its stored level again from the next cycle.
- R8: The core reset restores only the core-domain bits (mask 00FF00FFh) of the use-select, direction and level registers. Resume-domain bits and all blink bits keep their values.
- R9: The resume reset restores the resume-domain bits of the use-select, direction and level registers, the whole blink register, and the blink timebase.
- R10: A one-cycle pulse on swBlinkRst restores the blink register to 00040000h and takes priority over a blink write in the same cycle. Other registers are not affected.
- R11: The registers sit at byte offsets 00h (use-select), 04h (direction), 08h (level) and 0Ch (blink). Any other offset reads 0, and a write there changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| coreRstN | input | 1 | Core-domain reset, active low, asynchronous |
| resumeRstN | input | 1 | Resume-domain reset, active low, asynchronous |
| swBlinkRst | input | 1 | One-cycle strobe that restores the blink register |
| busAddr | input | 5 | Register byte offset |
| busWrEn | input | 1 | Write enable |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data for busAddr |
| pinIn | input | 32 | Pin input states |
| pinOut | output | 32 | Pin output values |
| pinOe | output | 32 | Pin output enables |

## Verification
The in-line properties check on every cycle four things:
- A level bit that is not a GPIO output never changes on a write.
- The stored level never moves without a level write.
- The blink phase flips only when the timebase wraps.
- The strobe restores the blink default, and native pins never read non-zero.

Only the bench scenarios can show the rest:
- The blink half-period measured at a pin.
- The two-edge input latency.
- The domain-specific effects of the core and resume resets.
- Whether the right register answers each offset.

// File: rtl/gpio_blink_pkg.sv
package gpio_blink_pkg;
  localparam int ADDR_W = 5;

  localparam logic [ADDR_W-1:0] OFS_USE   = 5'h00;
  localparam logic [ADDR_W-1:0] OFS_DIR   = 5'h04;
  localparam logic [ADDR_W-1:0] OFS_LVL   = 5'h08;
  localparam logic [ADDR_W-1:0] OFS_BLINK = 5'h0C;

  // Strobes and the shared phase, sent from the control to the datapath
  typedef struct packed {
    logic wrUse;
    logic wrDir;
    logic wrLvl;
    logic wrBlink;
    logic blinkClr;
    logic blinkPhase;
  } bankCtl_t;
endpackage

// File: rtl/gpio_blink_ctrl.sv
module gpio_blink_ctrl
  import gpio_blink_pkg::*;
#(
  parameter int CLK_HZ   = 200_000_000,
  parameter int BLINK_HZ = 1
) (
  input  logic              clk,
  input  logic              resumeRstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic              swRst,
  output bankCtl_t          ctl
);
  localparam int HALF  = CLK_HZ / (2 * BLINK_HZ);
  localparam int CNT_W = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF - 1);

  logic [CNT_W-1:0] halfCnt;
  logic             phase;

  // Half-period timebase: flips the shared phase each time it wraps
  always_ff @(posedge clk or negedge resumeRstN) begin
    if (!resumeRstN) begin
      halfCnt <= '0;
      phase   <= 1'b0;
    end else if (halfCnt == LAST) begin
      halfCnt <= '0;
      phase   <= ~phase;
    end else begin
      halfCnt <= halfCnt + 1'b1;
    end
  end

  always_comb begin
    ctl            = '0;
    ctl.wrUse      = wrEn && (addr == OFS_USE);
    ctl.wrDir      = wrEn && (addr == OFS_DIR);
    ctl.wrLvl      = wrEn && (addr == OFS_LVL);
    ctl.wrBlink    = wrEn && (addr == OFS_BLINK);
    ctl.blinkClr   = swRst;
    ctl.blinkPhase = phase;
  end

  // R5: the phase may only flip on the cycle after the counter wrapped
  p_phase_period_r5: assert property (@(posedge clk) disable iff (!resumeRstN)
    (phase != $past(phase)) |-> ($past(halfCnt) == LAST));
endmodule

// File: rtl/gpio_blink_dp.sv
module gpio_blink_dp
  import gpio_blink_pkg::*;
#(
  parameter int                    NUM_PINS  = 32,
  parameter logic [NUM_PINS-1:0]   CORE_MASK = 32'h00FF00FF,
  parameter logic [NUM_PINS-1:0]   USE_DEF   = 32'hFFFFFFFF,
  parameter logic [NUM_PINS-1:0]   DIR_DEF   = 32'h00040000,
  parameter logic [NUM_PINS-1:0]   LVL_DEF   = 32'h02FE0000,
  parameter logic [NUM_PINS-1:0]   BLINK_DEF = 32'h00040000
) (
  input  logic                clk,
  input  logic                coreRstN,
  input  logic                resumeRstN,
  input  bankCtl_t            ctl,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [NUM_PINS-1:0] wrData,
  input  logic [NUM_PINS-1:0] pinIn,
  output logic [NUM_PINS-1:0] rdData,
  output logic [NUM_PINS-1:0] pinOut,
  output logic [NUM_PINS-1:0] pinOe
);
  logic [NUM_PINS-1:0] useSel, dirOut, level, blink, pinSync;

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    logic bitRstN;
    logic useQ, dirQ, lvlQ, blinkQ, syncA, syncB;

    // Each pin's mode, level and synchroniser follow the reset of its domain
    assign bitRstN = CORE_MASK[i] ? coreRstN : resumeRstN;

    always_ff @(posedge clk or negedge bitRstN) begin
      if (!bitRstN) begin
        useQ  <= USE_DEF[i];
        dirQ  <= DIR_DEF[i];
        lvlQ  <= LVL_DEF[i];
        syncA <= 1'b0;
        syncB <= 1'b0;
      end else begin
        if (ctl.wrUse) useQ <= wrData[i];
        if (ctl.wrDir) dirQ <= wrData[i];
        if (ctl.wrLvl && useQ && dirQ) lvlQ <= wrData[i];
        syncA <= pinIn[i];
        syncB <= syncA;
      end
    end

    // Blink bits always live in the resume domain; the strobe wins over a write
    always_ff @(posedge clk or negedge resumeRstN) begin
      if (!resumeRstN)      blinkQ <= BLINK_DEF[i];
      else if (ctl.blinkClr) blinkQ <= BLINK_DEF[i];
      else if (ctl.wrBlink)  blinkQ <= wrData[i];
    end

    assign useSel[i]  = useQ;
    assign dirOut[i]  = dirQ;
    assign level[i]   = lvlQ;
    assign blink[i]   = blinkQ;
    assign pinSync[i] = syncB;
    assign pinOe[i]   = useQ & dirQ;
    assign pinOut[i]  = (blinkQ && useQ && dirQ) ? ctl.blinkPhase : lvlQ;
  end

  logic [NUM_PINS-1:0] lvlView;
  assign lvlView = (useSel & dirOut & level) | (useSel & ~dirOut & pinSync);

  always_comb begin
    case (addr)
      OFS_USE:   rdData = useSel;
      OFS_DIR:   rdData = dirOut;
      OFS_LVL:   rdData = lvlView;
      OFS_BLINK: rdData = blink;
      default:   rdData = '0;
    endcase
  end

  // R3/R4: a level write must leave every non-output bit untouched
  p_lvl_locked_r3: assert property (@(posedge clk) disable iff (!coreRstN || !resumeRstN)
    ctl.wrLvl |=> (((level ^ $past(level)) & ~$past(useSel & dirOut)) == '0));

  // R5: the stored level moves only on a level write, blinking or not
  p_lvl_hold_r5: assert property (@(posedge clk) disable iff (!coreRstN || !resumeRstN)
    !ctl.wrLvl |=> $stable(level));

  // R10: the software strobe restores the blink default
  p_blink_clr_r10: assert property (@(posedge clk) disable iff (!resumeRstN)
    ctl.blinkClr |=> (blink == BLINK_DEF));

  // R4: native pins never read back a set level bit
  p_native_rd_r4: assert property (@(posedge clk) disable iff (!coreRstN || !resumeRstN)
    (addr == OFS_LVL) |-> ((rdData & ~useSel) == '0));
endmodule

// File: rtl/gpio_blink_bank.sv
module gpio_blink_bank
  import gpio_blink_pkg::*;
#(
  parameter int                  NUM_PINS  = 32,
  parameter int                  CLK_HZ    = 200_000_000,
  parameter int                  BLINK_HZ  = 1,
  parameter logic [NUM_PINS-1:0] CORE_MASK = 32'h00FF00FF,
  parameter logic [NUM_PINS-1:0] USE_DEF   = 32'hFFFFFFFF,
  parameter logic [NUM_PINS-1:0] DIR_DEF   = 32'h00040000,
  parameter logic [NUM_PINS-1:0] LVL_DEF   = 32'h02FE0000,
  parameter logic [NUM_PINS-1:0] BLINK_DEF = 32'h00040000
) (
  input  logic                clk,
  input  logic                coreRstN,
  input  logic                resumeRstN,
  input  logic                swBlinkRst,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic                busWrEn,
  input  logic [NUM_PINS-1:0] busWrData,
  output logic [NUM_PINS-1:0] busRdData,
  input  logic [NUM_PINS-1:0] pinIn,
  output logic [NUM_PINS-1:0] pinOut,
  output logic [NUM_PINS-1:0] pinOe
);
  bankCtl_t ctl;

  gpio_blink_ctrl #(
    .CLK_HZ  (CLK_HZ),
    .BLINK_HZ(BLINK_HZ)
  ) u_ctrl (
    .clk       (clk),
    .resumeRstN(resumeRstN),
    .addr      (busAddr),
    .wrEn      (busWrEn),
    .swRst     (swBlinkRst),
    .ctl       (ctl)
  );

  gpio_blink_dp #(
    .NUM_PINS (NUM_PINS),
    .CORE_MASK(CORE_MASK),
    .USE_DEF  (USE_DEF),
    .DIR_DEF  (DIR_DEF),
    .LVL_DEF  (LVL_DEF),
    .BLINK_DEF(BLINK_DEF)
  ) u_dp (
    .clk       (clk),
    .coreRstN  (coreRstN),
    .resumeRstN(resumeRstN),
    .ctl       (ctl),
    .addr      (busAddr),
    .wrData    (busWrData),
    .pinIn     (pinIn),
    .rdData    (busRdData),
    .pinOut    (pinOut),
    .pinOe     (pinOe)
  );
endmodule

// File: tb/gpio_blink_bank_bench.sv
module gpio_blink_bank_bench;
  localparam int HALF = 20;

  logic        clk = 1'b0;
  logic        coreRstN = 1'b0, resumeRstN = 1'b0, swBlinkRst = 1'b0;
  logic [4:0]  busAddr = '0;
  logic        busWrEn = 1'b0;
  logic [31:0] busWrData = '0, busRdData, pinIn = 32'hA5A50F0F, pinOut, pinOe;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  gpio_blink_bank #(.CLK_HZ(2 * HALF), .BLINK_HZ(1)) u_gpio_blink_bank (
    .clk(clk), .coreRstN(coreRstN), .resumeRstN(resumeRstN), .swBlinkRst(swBlinkRst),
    .busAddr(busAddr), .busWrEn(busWrEn), .busWrData(busWrData), .busRdData(busRdData),
    .pinIn(pinIn), .pinOut(pinOut), .pinOe(pinOe)
  );

  typedef struct packed {
    logic        wr;
    logic [4:0]  addr;
    logic [31:0] data;
    logic [31:0] expv;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 5'h00, 32'h0,        32'hFFFFFFFF, 8'd1},  // R1 use default
    '{1'b0, 5'h04, 32'h0,        32'h00040000, 8'd1},  // R1 dir default
    '{1'b0, 5'h0C, 32'h0,        32'h00040000, 8'd1},  // R1 blink default
    '{1'b0, 5'h08, 32'h0,        32'hA5A50F0F, 8'd3},  // R3 inputs read pins
    '{1'b1, 5'h00, 32'hFFFFFF00, 32'h0,        8'd4},  // pins 0-7 native
    '{1'b1, 5'h04, 32'h0000FFFF, 32'h0,        8'd2},
    '{1'b1, 5'h08, 32'h5A5A3C3C, 32'h0,        8'd2},
    '{1'b0, 5'h08, 32'h0,        32'hA5A53C00, 8'd2},  // R2 R3 R4 mixed view
    '{1'b1, 5'h0C, 32'h0,        32'h0,        8'd11},
    '{1'b0, 5'h0C, 32'h0,        32'h0,        8'd11}, // R11
    '{1'b1, 5'h14, 32'hFFFFFFFF, 32'h0,        8'd11}, // R11 unmapped write
    '{1'b0, 5'h10, 32'h0,        32'h0,        8'd11}, // R11 unmapped read
    '{1'b1, 5'h04, 32'hFFFFFFFF, 32'h0,        8'd11},
    '{1'b0, 5'h08, 32'h0,        32'h02FE3C00, 8'd3},  // R3 input writes ignored
    '{1'b1, 5'h00, 32'hFFFFFFFF, 32'h0,        8'd4},
    '{1'b0, 5'h08, 32'h0,        32'h02FE3C00, 8'd4}   // R4 native writes ignored
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, expv);
    end
  endtask

  task automatic busWrite(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic busRead(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWrEn = 1'b0;
    #1 d = busRdData;
  endtask

  // Cycles between two successive changes of pinOut[idx]
  task automatic measure(input int idx, output int n);
    logic prev;
    int guard;
    n = 0; guard = 0;
    @(negedge clk); prev = pinOut[idx];
    while (pinOut[idx] == prev && guard < 200) begin @(negedge clk); guard++; end
    prev = pinOut[idx];
    while (guard < 200) begin
      @(negedge clk); n++; guard++;
      if (pinOut[idx] != prev) break;
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finishRun();
  end

  initial begin
    logic [31:0] rd;
    int n;
    bit ok;
    repeat (4) @(negedge clk);
    coreRstN = 1'b1; resumeRstN = 1'b1;
    repeat (3) @(negedge clk);

    // R1: pin 18 drives the blink phase out of reset; R5 half-period
    check("R1 pin18 oe", {31'b0, pinOe[18]}, 32'h1);
    measure(18, n);
    check("R5 default half-period", n, HALF);

    for (int k = 0; k < NV; k++) begin
      if (VECS[k].wr) busWrite(VECS[k].addr, VECS[k].data);
      else begin
        busRead(VECS[k].addr, rd);
        check($sformatf("R%0d vector %0d", VECS[k].req, k), rd, VECS[k].expv);
      end
    end

    // R2: output enables and a level write reaching the pins
    #1 check("R2 oe all", pinOe, 32'hFFFFFFFF);
    busWrite(5'h08, 32'h000004FF);
    #1 check("R2 pin drive", pinOut, 32'h000004FF);

    // R3: two-edge synchroniser latency on an input pin
    busWrite(5'h04, 32'hFFFFFFFE);
    @(negedge clk); pinIn[0] = 1'b0; busAddr = 5'h08;
    @(negedge clk); #1 check("R3 one edge", {31'b0, busRdData[0]}, 32'h1);
    @(negedge clk); #1 check("R3 two edges", {31'b0, busRdData[0]}, 32'h0);
    pinIn[0] = 1'b1;
    busWrite(5'h04, 32'hFFFFFFFF);

    // R5: blink on pin 10, stored level unchanged
    busWrite(5'h0C, 32'h00000400);
    measure(10, n);
    check("R5 pin10 half-period", n, HALF);
    busRead(5'h08, rd);
    check("R5 level kept", rd, 32'h000004FF);

    // R6: blink on an input pin has no effect
    busWrite(5'h04, 32'hFFFFFBFF);
    ok = 1;
    for (int c = 0; c < 2 * HALF + 4; c++) begin
      @(negedge clk); #1 if (pinOe[10] !== 1'b0) ok = 0;
    end
    check("R6 oe stays low", {31'b0, ok}, 32'h1);
    busRead(5'h08, rd);
    check("R6 read pin", rd, 32'h000004FF);
    busWrite(5'h04, 32'hFFFFFFFF);

    // R7: clearing blink returns to the stored level
    busWrite(5'h0C, 32'h0);
    ok = 1;
    for (int c = 0; c < 2 * HALF + 4; c++) begin
      @(negedge clk); #1 if (pinOut[10] !== 1'b1) ok = 0;
    end
    check("R7 steady level", {31'b0, ok}, 32'h1);

    // R10: software strobe restores blink only, beating a same-cycle write
    busWrite(5'h0C, 32'hFFFFFFFF);
    @(negedge clk);
    swBlinkRst = 1'b1; busAddr = 5'h0C; busWrData = 32'h0000FFFF; busWrEn = 1'b1;
    @(negedge clk); swBlinkRst = 1'b0; busWrEn = 1'b0;
    busRead(5'h0C, rd);
    check("R10 blink default", rd, 32'h00040000);
    busRead(5'h04, rd);
    check("R10 dir untouched", rd, 32'hFFFFFFFF);

    // R8: core reset hits core-domain bits only
    busWrite(5'h08, 32'h12345678);
    busWrite(5'h0C, 32'h00000002);
    @(negedge clk); coreRstN = 1'b0;
    @(negedge clk); coreRstN = 1'b1;
    busRead(5'h04, rd);
    check("R8 dir", rd, 32'hFF04FF00);
    busRead(5'h0C, rd);
    check("R8 blink kept", rd, 32'h00000002);
    check("R8 resume pins", pinOut & 32'hFF00FF00, 32'h12005600);
    check("R8 oe", pinOe, 32'hFF04FF00);

    // R9: resume reset hits resume-domain bits and the blink register
    @(negedge clk); resumeRstN = 1'b0;
    @(negedge clk); resumeRstN = 1'b1;
    busRead(5'h04, rd);
    check("R9 dir", rd, 32'h00040000);
    busRead(5'h0C, rd);
    check("R9 blink", rd, 32'h00040000);
    #1 check("R9 oe", pinOe, 32'h00040000);

    finishRun();
  end
endmodule